// File: doc/BRIEF.md
# Double-Width Integer Divider with Divide-Error Detection

This block divides a dividend of twice the operand width by a divisor of one operand width and returns a quotient and a remainder. Four operand sizes are selectable (8, 16, 32 and 64 bits), and each can be treated as unsigned or as two's-complement signed. The dividend is presented as a high half and a low half; only the low N bits of each half and of the divisor take part for an N-bit operation, and the results are zero-extended to the full port width.

A request is accepted by pulsing `start_i` while the unit is idle. The unit then stays busy for a fixed number of cycles: one setup cycle, one cycle per quotient bit in a restoring shift-subtract loop, and one finishing cycle that applies signs and checks the signed range. A zero divisor, or an unsigned high half that is already at least the divisor, ends the request in the setup cycle. All failure causes share one divide-error indication that is raised together with `done_o`. When it is raised, the result registers keep their previous contents.

Top module: `int_divider`

## Requirements
- R1: With `size_i`=0 (8-bit), the dividend is {hi_i[7:0], lo_i[7:0]} and the divisor is dvs_i[7:0]; `quo_o` and `rem_o` carry the 8-bit quotient and remainder with zeros above bit 7. Bits above the operand width on any input have no effect.
- R2: With `size_i`=1, 2 or 3 (16, 32 or 64 bits), the dividend is {hi_i[N-1:0], lo_i[N-1:0]}; in unsigned mode (`signed_i`=0) the quotient and remainder of the 2N-bit by N-bit division appear on `quo_o` and `rem_o`, zero-extended.
- R3: A divisor whose low N bits are all zero raises `err_o` with `done_o`; `quo_o` and `rem_o` keep their previous values.
- R4: In unsigned mode, when hi_i[N-1:0] is greater than or equal to the divisor, `err_o` is raised and results are not written; this completes in the setup cycle.
- R5: In signed mode (`signed_i`=1), operands are two's-complement; the quotient is truncated toward zero and the remainder carries the sign of the dividend (or is zero).
- R6: In signed mode, a result is an error when the true quotient lies outside [-2^(N-1), 2^(N-1)-1]; a quotient of exactly -2^(N-1) is valid.
- R7: Counting the rising edge that samples `start_i` as edge 1, `done_o` is high after edge N+3 for a request that runs the loop, and after edge 2 for one rejected in setup (zero divisor or unsigned early overflow).
- R8: After reset `busy_o`, `done_o`, `err_o`, `quo_o` and `rem_o` are zero. `done_o` is a one-cycle pulse; `err_o` is only high together with `done_o`.
- R9: Size, sign mode and operands are captured when a request is accepted; changes to any input, including further `start_i` pulses, while `busy_o` is high have no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| size_i | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| signed_i | input | 1 | 1 selects two's-complement division |
| hi_i | input | XLEN | High half of the dividend |
| lo_i | input | XLEN | Low half of the dividend |
| dvs_i | input | XLEN | Divisor |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error, valid with done_o |
| quo_o | output | XLEN | Quotient, zero-extended |
| rem_o | output | XLEN | Remainder, zero-extended |

## Verification
On every cycle the assertions check that the completion pulse lasts one cycle, that the error flag never appears without it, that an error leaves both result registers untouched, that the partial remainder stays below the divisor magnitude throughout the loop, that the iteration count stays within the operand width, and that the captured size does not change mid-request. Only the directed scenarios can show the arithmetic itself: correct quotients and remainders at each size, sign handling for each sign combination, the asymmetric signed limit around -2^(N-1), masking of bits above the operand width, the exact latency per size, and that inputs driven during a busy request are ignored.

// File: rtl/int_div_pkg.sv
`timescale 1ns/1ps
package int_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ITER   = 2'd2,
    ST_FINISH = 2'd3
  } div_state_t;

  // operand size code to bit count: 0->8, 1->16, 2->32, 3->64
  function automatic int unsigned width_of(input logic [1:0] sz);
    return 32'd8 << sz;
  endfunction

endpackage

// File: rtl/int_div_prep.sv
`timescale 1ns/1ps
module int_div_prep #(
  parameter int XLEN = 64
) (
  input  logic            sgn_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] dv_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] half_i,
  output logic [XLEN-1:0] hi_mag_o,
  output logic [XLEN-1:0] lo_mag_o,
  output logic [XLEN-1:0] dv_mag_o,
  output logic            dvd_neg_o,
  output logic            dvs_neg_o,
  output logic            dv_zero_o,
  output logic            hi_ovf_o
);
  logic [XLEN-1:0] hi_m, lo_m, dv_m, hi_n, lo_n, dv_n;
  logic            lo_zero;

  always_comb begin
    hi_m      = hi_i & mask_i;
    lo_m      = lo_i & mask_i;
    dv_m      = dv_i & mask_i;
    dvd_neg_o = sgn_i & (|(hi_m & half_i));
    dvs_neg_o = sgn_i & (|(dv_m & half_i));
    // negate the double-width dividend: carry into the high half only when low half is zero
    lo_zero   = (lo_m == '0);
    lo_n      = (~lo_m + XLEN'(1)) & mask_i;
    hi_n      = (~hi_m + XLEN'(lo_zero)) & mask_i;
    dv_n      = (~dv_m + XLEN'(1)) & mask_i;
    hi_mag_o  = dvd_neg_o ? hi_n : hi_m;
    lo_mag_o  = dvd_neg_o ? lo_n : lo_m;
    dv_mag_o  = dvs_neg_o ? dv_n : dv_m;
    dv_zero_o = (dv_m == '0);
    hi_ovf_o  = (hi_mag_o >= dv_mag_o);
  end
endmodule

// File: rtl/int_div_step.sv
`timescale 1ns/1ps
module int_div_step #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rem_i,
  input  logic [XLEN-1:0] quo_i,
  input  logic [XLEN-1:0] dv_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            msb_i,
  output logic [XLEN-1:0] rem_o,
  output logic [XLEN-1:0] quo_o
);
  logic [XLEN:0] shifted, diff;
  logic          take;

  always_comb begin
    // one extra bit keeps the bit shifted out of the partial remainder
    shifted = {rem_i, msb_i};
    diff    = shifted - {1'b0, dv_i};
    take    = (shifted >= {1'b0, dv_i});
    rem_o   = take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    quo_o   = {quo_i[XLEN-2:0], take} & mask_i;
  end
endmodule

// File: rtl/int_div_fixup.sv
`timescale 1ns/1ps
module int_div_fixup #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] q_i,
  input  logic [XLEN-1:0] r_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] half_i,
  input  logic            sgn_i,
  input  logic            dvd_neg_i,
  input  logic            dvs_neg_i,
  output logic [XLEN-1:0] q_o,
  output logic [XLEN-1:0] r_o,
  output logic            ovf_o
);
  logic differ;

  always_comb begin
    differ = dvd_neg_i ^ dvs_neg_i;
    // a negative quotient may reach magnitude 2^(N-1); a positive one may not
    ovf_o  = sgn_i & (differ ? (q_i > half_i) : (q_i >= half_i));
    q_o    = differ ? ((~q_i + XLEN'(1)) & mask_i) : q_i;
    r_o    = dvd_neg_i ? ((~r_i + XLEN'(1)) & mask_i) : r_i;
  end
endmodule

// File: rtl/int_divider.sv
`timescale 1ns/1ps
module int_divider #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [1:0]      size_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  import int_div_pkg::*;

  localparam int CNTW = $clog2(XLEN) + 1;

  div_state_t      state_q;
  logic [1:0]      sz_q;
  logic            sgn_q, dvd_neg_q, dvs_neg_q;
  logic [XLEN-1:0] hi_q, lo_q, dv_q;
  logic [XLEN-1:0] rem_q, quo_q, dmag_q;
  logic [CNTW-1:0] cnt_q;

  logic [CNTW-1:0] nbits;
  logic [XLEN-1:0] mask, half;

  always_comb begin
    nbits = CNTW'(width_of(sz_q));
    mask  = (int'(nbits) >= XLEN) ? '1 : ((XLEN'(1) << nbits) - XLEN'(1));
    half  = XLEN'(1) << (nbits - CNTW'(1));
  end

  logic [XLEN-1:0] hi_mag, lo_mag, dv_mag;
  logic            p_dvd_neg, p_dvs_neg, p_zero, p_ovf;

  int_div_prep #(.XLEN(XLEN)) u_prep (
    .sgn_i(sgn_q), .hi_i(hi_q), .lo_i(lo_q), .dv_i(dv_q),
    .mask_i(mask), .half_i(half),
    .hi_mag_o(hi_mag), .lo_mag_o(lo_mag), .dv_mag_o(dv_mag),
    .dvd_neg_o(p_dvd_neg), .dvs_neg_o(p_dvs_neg),
    .dv_zero_o(p_zero), .hi_ovf_o(p_ovf)
  );

  logic [XLEN-1:0] s_rem, s_quo;
  logic            lo_msb;
  assign lo_msb = |(quo_q & half);

  int_div_step #(.XLEN(XLEN)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dv_i(dmag_q), .mask_i(mask),
    .msb_i(lo_msb), .rem_o(s_rem), .quo_o(s_quo)
  );

  logic [XLEN-1:0] f_quo, f_rem;
  logic            f_ovf;

  int_div_fixup #(.XLEN(XLEN)) u_fix (
    .q_i(quo_q), .r_i(rem_q), .mask_i(mask), .half_i(half),
    .sgn_i(sgn_q), .dvd_neg_i(dvd_neg_q), .dvs_neg_i(dvs_neg_q),
    .q_o(f_quo), .r_o(f_rem), .ovf_o(f_ovf)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sz_q      <= '0;
      sgn_q     <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      dv_q      <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dmag_q    <= '0;
      dvd_neg_q <= 1'b0;
      dvs_neg_q <= 1'b0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      quo_o     <= '0;
      rem_o     <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sz_q    <= size_i;
            sgn_q   <= signed_i;
            hi_q    <= hi_i;
            lo_q    <= lo_i;
            dv_q    <= dvs_i;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (p_zero || p_ovf) begin
            done_o  <= 1'b1;
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rem_q     <= hi_mag;
            quo_q     <= lo_mag;
            dmag_q    <= dv_mag;
            dvd_neg_q <= p_dvd_neg;
            dvs_neg_q <= p_dvs_neg;
            cnt_q     <= '0;
            state_q   <= ST_ITER;
          end
        end
        ST_ITER: begin
          rem_q <= s_rem;
          quo_q <= s_quo;
          cnt_q <= cnt_q + CNTW'(1);
          if (cnt_q == nbits - CNTW'(1)) state_q <= ST_FINISH;
        end
        ST_FINISH: begin
          done_o <= 1'b1;
          if (f_ovf) begin
            err_o <= 1'b1;
          end else begin
            quo_o <= f_quo;
            rem_o <= f_rem;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_no_write_on_err_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> ($stable(quo_o) && $stable(rem_o)));

  assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ITER) |-> (rem_q < dmag_q));

  assert_iter_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ITER) |-> (cnt_q < nbits));

  assert_size_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && !$past(rst)) |-> $stable(sz_q));

endmodule

// File: tb/sim_int_divider.sv
`timescale 1ns/1ps
module sim_int_divider;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [1:0]      size_i = '0;
  logic            signed_i = 1'b0;
  logic [XLEN-1:0] hi_i = '0, lo_i = '0, dvs_i = '0;
  logic            busy_o, done_o, err_o;
  logic [XLEN-1:0] quo_o, rem_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  int_divider #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .signed_i(signed_i),
    .hi_i(hi_i), .lo_i(lo_i), .dvs_i(dvs_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .quo_o(quo_o), .rem_o(rem_o)
  );

  task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference from the requirements using wide arithmetic
  task automatic model(input logic [1:0] sz, input bit sg, input logic [63:0] hi, lo, dv,
                       output bit e_err, output logic [63:0] e_q, output logic [63:0] e_r,
                       output int e_lat);
    int n;
    logic [127:0] m, dd, vv, uq, ur;
    logic signed [127:0] sd, sv, sq, sr, lim;
    n  = 8 << sz;
    m  = (128'(1) << n) - 128'(1);
    dd = ((128'(hi) & m) << n) | (128'(lo) & m);
    vv = 128'(dv) & m;
    e_q = '0; e_r = '0;
    if (vv == 0) begin
      e_err = 1'b1; e_lat = 2;
    end else if (!sg) begin
      uq = dd / vv; ur = dd % vv;
      e_err = (uq > m);
      e_lat = e_err ? 2 : n + 3;
      e_q = uq[63:0]; e_r = ur[63:0];
    end else begin
      sd  = $signed(dd << (128 - 2*n)) >>> (128 - 2*n);
      sv  = $signed(vv << (128 - n)) >>> (128 - n);
      sq  = sd / sv; sr = sd % sv;
      lim = $signed(128'(1) << (n - 1));
      e_err = (sq >= lim) || (sq < -lim);
      e_lat = e_err ? -1 : n + 3;
      e_q = 64'(sq & $signed(m)); e_r = 64'(sr & $signed(m));
    end
  endtask

  task automatic run_div(input string tag, input logic [1:0] sz, input bit sg,
                         input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] dv,
                         input bit disturb);
    bit e_err; logic [63:0] e_q, e_r, pq, pr; int e_lat, cyc;
    model(sz, sg, hi, lo, dv, e_err, e_q, e_r, e_lat);
    @(negedge clk);
    pq = quo_o; pr = rem_o;
    size_i = sz; signed_i = sg; hi_i = hi; lo_i = lo; dvs_i = dv; start_i = 1'b1;
    @(negedge clk);
    cyc = 1;
    start_i = 1'b0;
    if (disturb) begin
      size_i = 2'd3; signed_i = ~sg; hi_i = 64'h0; lo_i = 64'h5; dvs_i = 64'h1; start_i = 1'b1;
    end
    while (!done_o && cyc < 300) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
    end
    if (cyc >= 300) begin
      fails++; checks++;
      $display("FAIL %s timeout: actual %0d expected done", tag, cyc);
      return;
    end
    if (e_lat >= 0) check({tag, " R7"}, "latency", 128'(cyc), 128'(e_lat));
    check(tag, "err", 128'(err_o), 128'(e_err));
    if (e_err) begin
      check({tag, " R3"}, "quotient kept", 128'(quo_o), 128'(pq));
      check({tag, " R3"}, "remainder kept", 128'(rem_o), 128'(pr));
    end else begin
      check(tag, "quotient", 128'(quo_o), 128'(e_q));
      check(tag, "remainder", 128'(rem_o), 128'(e_r));
    end
    @(negedge clk);
    check({tag, " R8"}, "done pulse width", 128'(done_o), 128'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset", "busy", 128'(busy_o), 128'(0));
    check("R8 reset", "done", 128'(done_o), 128'(0));
    check("R8 reset", "quotient", 128'(quo_o), 128'(0));
    check("R8 reset", "remainder", 128'(rem_o), 128'(0));

    run_div("R1 byte unsigned masked", 2'd0, 1'b0, 64'hDEAD_BEEF_0000_0012, 64'hCAFE_0000_0000_0034, 64'h1234_5678_9ABC_0056, 1'b0);
    run_div("R5 byte signed -100/7",   2'd0, 1'b1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_009C, 64'h7, 1'b0);
    run_div("R6 byte signed -256/2",   2'd0, 1'b1, 64'hFF, 64'h00, 64'h02, 1'b0);
    run_div("R6 byte signed 256/2",    2'd0, 1'b1, 64'h01, 64'h00, 64'h02, 1'b0);
    run_div("R6 byte signed -256/-2",  2'd0, 1'b1, 64'hFF, 64'h00, 64'hFE, 1'b0);
    run_div("R2 word unsigned",        2'd1, 1'b0, 64'h0001, 64'h0000, 64'h0003, 1'b0);
    run_div("R5 word signed 100/-7",   2'd1, 1'b1, 64'h0000, 64'h0064, 64'hFFF9, 1'b0);
    run_div("R5 dword signed",         2'd2, 1'b1, 64'hFFFF_FFFF, 64'hC465_3600, 64'hFFFF_FFF9, 1'b0);
    run_div("R2 qword unsigned",       2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'hF000_0000_0000_0001, 1'b0);
    run_div("R5 qword signed",         2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h3, 1'b0);
    run_div("R7 qword small",          2'd3, 1'b0, 64'h0, 64'd100, 64'd7, 1'b0);
    run_div("R3 word zero divisor",    2'd1, 1'b0, 64'h0000, 64'h1234, 64'hFFFF_0000, 1'b0);
    run_div("R4 dword early overflow", 2'd2, 1'b0, 64'h5, 64'h0, 64'h5, 1'b0);
    run_div("R9 inputs ignored busy",  2'd0, 1'b0, 64'h0F, 64'hFF, 64'h10, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule